// File: doc/BRIEF.md
# Converter Output Data Formatter

This block sits between an 11-bit pipelined sampling core and the parallel data pins of the device. On every sample clock it captures one raw sample code, which is always offset binary, together with an out-of-range flag. Both travel through a fixed-latency delay line, and the code is re-encoded on the way out. The delay line is 10 sample clocks deep in normal operation and 13 deep when the noise-shaping mode is on. The flag reaches the pins in the same cycle as the sample it belongs to.

A small write-only configuration port holds one control register. The register selects the output encoding (offset binary, two's complement or Gray), turns the noise-shaping latency on or off, and can release the data pins to high impedance. The output disable is a static setting and is not meant for cycle-by-cycle bus sharing. A change of noise-shaping mode flushes the delay line. The output valid flag stays low until samples captured under the new latency reach the pins.

Top module: `adcfmt_top`

## Requirements
- R1: After a synchronous active-low reset, the format is two's complement, noise shaping is off, the data pins are enabled (`pin_oe` = 1) and `pin_valid` is 0 until the delay line has filled.
- R2: With noise shaping off, a sample captured at clock edge t appears on `pin_data` after edge t+9, that is 10 capture edges inclusive. `pin_valid` rises after the 10th edge following reset or flush.
- R3: With noise shaping on, the same path is 13 edges long, and `pin_valid` rises after the 13th edge following the flush.
- R4: `pin_ovr` carries the out-of-range flag of the sample currently on `pin_data`, delayed by exactly the same number of edges.
- R5: Format code 0 (offset binary) drives the raw code unchanged: 000 0000 0000 for negative full scale, 100 0000 0000 for midscale, 111 1111 1111 for positive full scale.
- R6: Format code 1 (two's complement) inverts the most significant bit only. Negative full scale, midscale and positive full scale give 100 0000 0000, 000 0000 0000 and 011 1111 1111.
- R7: Format code 2 (Gray) drives raw XOR (raw shifted right by one). The reserved format code 3 behaves as two's complement.
- R8: The control register is at address 0x14. It holds the format in bits [1:0], noise-shaping enable in bit 2 and output disable in bit 4, active high. While the disable bit is set, `pin_oe` is 0 and `pin_data` is released to high impedance. From the cycle after the write, `pin_oe` equals the inverse of the written bit.
- R9: A write strobe with any address other than 0x14 changes no setting and does not disturb valid output data.
- R10: A write that changes the noise-shaping bit flushes the delay line. `pin_valid` falls after that write edge and rises again only once the new latency has elapsed. A write that keeps the bit unchanged does not flush.
- R11: A format change takes effect on the output register at the edge after the write, with no flush and no drop of `pin_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_code | input | 11 | Raw offset-binary sample from the core |
| smp_ovr | input | 1 | Out-of-range flag for `smp_code` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| pin_data | output | 11 | Encoded sample, high impedance when disabled |
| pin_ovr | output | 1 | Out-of-range flag aligned with `pin_data` |
| pin_valid | output | 1 | Delay line has filled since reset or the last flush |
| pin_oe | output | 1 | Data pin drive enable |

## Verification
Two cases can land in the same cycle: a configuration write that changes the output encoding while data is streaming, and the delay line presenting a sample captured before that write. The write may also change the latency, which starts a flush in the same edge that the output register loads its last old sample. The bench provokes both with directed writes in the middle of random streams and with random writes scattered through a long run. A reference model applies the old format to the edge that carries the write and the new one from the next edge on. It also restarts its fill count only when the noise-shaping bit actually changes, and it compares data, flag, valid and enable after every edge.

// File: rtl/adcfmt_pkg.sv
// Package: shared types and register layout for the output data formatter.
// Assumes a single control register; every field position is defined here.
package adcfmt_pkg;

    // Output encoding selector; code 3 is reserved and treated as two's complement.
    typedef enum logic [1:0] {
        FMT_OFFSET   = 2'd0,
        FMT_TWOS     = 2'd1,
        FMT_GRAY     = 2'd2,
        FMT_RESERVED = 2'd3
    } fmt_e;

    // Decoded control register contents.
    typedef struct packed {
        logic out_dis;
        logic ns_en;
        fmt_e fmt;
    } ctrl_t;

    localparam logic [7:0] CTRL_ADDR = 8'h14;
    localparam int         FMT_LSB   = 0;
    localparam int         NS_BIT    = 2;
    localparam int         DIS_BIT   = 4;

    localparam ctrl_t CTRL_RESET = '{out_dis: 1'b0, ns_en: 1'b0, fmt: FMT_TWOS};

endpackage

// File: rtl/adcfmt_regs.sv
// Module: control register for the formatter.
// Holds format, noise-shaping enable and output disable. Writes to any
// other address are dropped. Raises flush for the write that changes
// the noise-shaping bit (combinational, aligned with the write edge).
module adcfmt_regs
    import adcfmt_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic          flush
);

    localparam logic [AW-1:0] HIT_ADDR = AW'(CTRL_ADDR);

    ctrl_t ctrl_q;
    ctrl_t ctrl_d;
    logic  hit;

    // Address decode for the single control register.
    always_comb begin
        hit = we && (addr == HIT_ADDR);
    end

    // Unpack the written word into register fields.
    always_comb begin
        ctrl_d.fmt     = fmt_e'(wdata[FMT_LSB +: 2]);
        ctrl_d.ns_en   = wdata[NS_BIT];
        ctrl_d.out_dis = wdata[DIS_BIT];
    end

    // Register update on a hit, defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (hit) begin
            ctrl_q <= ctrl_d;
        end
    end

    // Flush request when the latency mode toggles.
    always_comb begin
        flush = hit && (ctrl_d.ns_en != ctrl_q.ns_en);
    end

    assign ctrl = ctrl_q;

    logic unused_wdata;
    assign unused_wdata = ^{wdata[DW-1:DIS_BIT+1], wdata[DIS_BIT-1:NS_BIT+1]};

    AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != HIT_ADDR) |=> $stable(ctrl_q)) else $error("write to foreign address changed control"); // R9

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (ctrl_q == CTRL_RESET)) else $error("control not at defaults after reset"); // R1

endmodule

// File: rtl/adcfmt_pipe.sv
// Module: latency delay line for sample code and out-of-range flag.
// Chain of LAT_LONG-1 stages; the output register in the top adds one
// more, so the tap sits at LAT-2. Also owns the fill counter behind the
// valid flag. Flush clears all stages and restarts the fill count.
module adcfmt_pipe #(
    parameter int W         = 11,
    parameter int LAT_SHORT = 10,
    parameter int LAT_LONG  = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         long_mode,
    input  logic [W-1:0] in_code,
    input  logic         in_ovr,
    output logic [W-1:0] tap_code,
    output logic         tap_ovr,
    output logic         valid
);

    localparam int DEPTH     = LAT_LONG - 1;
    localparam int CW        = $clog2(LAT_LONG + 1);
    localparam int TAP_SHORT = LAT_SHORT - 2;
    localparam int TAP_LONG  = LAT_LONG - 2;
    localparam logic [CW-1:0] LIM_SHORT = CW'(LAT_SHORT);
    localparam logic [CW-1:0] LIM_LONG  = CW'(LAT_LONG);

    logic [W:0]    stg [DEPTH];
    logic [CW-1:0] fill_q;
    logic [CW-1:0] lim;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            if (k == 0) begin : g_head
                // First stage captures the incoming sample and flag.
                always_ff @(posedge clk) begin
                    if (!rst_n || flush) begin
                        stg[k] <= '0;
                    end else begin
                        stg[k] <= {in_ovr, in_code};
                    end
                end
            end else begin : g_body
                // Later stages shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n || flush) begin
                        stg[k] <= '0;
                    end else begin
                        stg[k] <= stg[k-1];
                    end
                end
            end
        end
    endgenerate

    // Tap selection by latency mode.
    always_comb begin
        if (long_mode) begin
            {tap_ovr, tap_code} = stg[TAP_LONG];
        end else begin
            {tap_ovr, tap_code} = stg[TAP_SHORT];
        end
    end

    // Active latency limit for the fill counter.
    always_comb begin
        lim = long_mode ? LIM_LONG : LIM_SHORT;
    end

    // Fill counter: edges since reset or flush, saturating at the long latency.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            fill_q <= '0;
        end else if (fill_q < LIM_LONG) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // Output valid once the active latency has elapsed.
    always_comb begin
        valid = (fill_q >= lim);
    end

    AST_FLUSH_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid) else $error("valid survived a flush"); // R10

    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= LIM_LONG) else $error("fill count past long latency"); // R3

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flush) |=> valid) else $error("valid dropped without a flush"); // R11

endmodule

// File: rtl/adcfmt_encode.sv
// Module: combinational re-encoder from offset binary.
// Two's complement inverts the top bit; Gray XORs each bit with the next
// higher one. The reserved code falls back to two's complement.
module adcfmt_encode
    import adcfmt_pkg::*;
#(
    parameter int W = 11
) (
    input  fmt_e         fmt,
    input  logic [W-1:0] bin,
    output logic [W-1:0] code
);

    logic [W-1:0] gray;
    logic [W-1:0] twos;

    generate
        for (genvar i = 0; i < W; i++) begin : g_gray
            if (i == W - 1) begin : g_top
                assign gray[i] = bin[i];
            end else begin : g_low
                assign gray[i] = bin[i] ^ bin[i+1];
            end
        end
    endgenerate

    // Two's complement by top-bit inversion.
    always_comb begin
        twos = {~bin[W-1], bin[W-2:0]};
    end

    // Format selection.
    always_comb begin
        unique case (fmt)
            FMT_OFFSET: code = bin;
            FMT_GRAY:   code = gray;
            default:    code = twos;
        endcase
    end

endmodule

// File: rtl/adcfmt_top.sv
// Module: converter output data formatter top.
// Captures one raw offset-binary sample and flag per clock, delays them by
// the mode-dependent latency, re-encodes and registers the result, and
// drives tristate data pins under register control. Reset is synchronous,
// active low.
module adcfmt_top
    import adcfmt_pkg::*;
#(
    parameter int W         = 11,
    parameter int LAT_SHORT = 10,
    parameter int LAT_LONG  = 13,
    parameter int AW        = 8,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  smp_code,
    input  logic          smp_ovr,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [W-1:0]  pin_data,
    output logic          pin_ovr,
    output logic          pin_valid,
    output logic          pin_oe
);

    ctrl_t        ctrl;
    logic         flush;
    logic [W-1:0] tap_code;
    logic         tap_ovr;
    logic [W-1:0] enc_code;
    logic [W-1:0] data_q;
    logic         ovr_q;

    adcfmt_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .flush (flush)
    );

    adcfmt_pipe #(.W(W), .LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .long_mode (ctrl.ns_en),
        .in_code   (smp_code),
        .in_ovr    (smp_ovr),
        .tap_code  (tap_code),
        .tap_ovr   (tap_ovr),
        .valid     (pin_valid)
    );

    adcfmt_encode #(.W(W)) u_enc (
        .fmt  (ctrl.fmt),
        .bin  (tap_code),
        .code (enc_code)
    );

    // Output register: last latency stage, holds encoded data and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            data_q <= enc_code;
            ovr_q  <= tap_ovr;
        end
    end

    // Pin drive: static enable from the control register.
    always_comb begin
        pin_oe  = !ctrl.out_dis;
        pin_ovr = ovr_q;
    end

    assign pin_data = pin_oe ? data_q : 'z;

    AST_OE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == AW'(CTRL_ADDR)) |=> (pin_oe == !$past(cfg_wdata[DIS_BIT]))) else $error("enable does not follow written disable bit"); // R8

endmodule

// File: tb/adcfmt_top_bench.sv
module adcfmt_top_bench;

    localparam int W = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  smp_code = '0;
    logic          smp_ovr = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [W-1:0]  pin_data;
    logic          pin_ovr;
    logic          pin_valid;
    logic          pin_oe;

    adcfmt_top u_adcfmt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_code  (smp_code),
        .smp_ovr   (smp_ovr),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pin_data  (pin_data),
        .pin_ovr   (pin_ovr),
        .pin_valid (pin_valid),
        .pin_oe    (pin_oe)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Reference model state
    logic [W:0] hist [16];
    logic [1:0] m_fmt = 2'd1;
    logic       m_ns  = 1'b0;
    logic       m_dis = 1'b0;
    int         m_cnt = 0;
    string      ctx   = "";

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [W-1:0] enc(input logic [1:0] f, input logic [W-1:0] b);
        if (f == 2'd0) return b;
        if (f == 2'd2) return b ^ (b >> 1);
        return {~b[W-1], b[W-2:0]};
    endfunction

    function automatic string fmt_tag(input logic [1:0] f);
        if (f == 2'd0) return "R5";
        if (f == 2'd1) return "R6";
        return "R7";
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: model update and checks at the falling edge, then new stimulus.
    task automatic step();
        logic [1:0]   old_fmt;
        logic         hit;
        int           lat;
        logic [W-1:0] exp_d;
        logic         exp_o;
        string        tv;
        string        td;
        @(posedge clk);
        @(negedge clk);
        for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = {smp_ovr, smp_code};
        old_fmt = m_fmt;
        hit = cfg_we && (cfg_addr == 8'h14);
        if (hit && (cfg_wdata[2] != m_ns)) begin
            m_cnt = 0;
        end else if (m_cnt < 13) begin
            m_cnt = m_cnt + 1;
        end
        if (hit) begin
            m_fmt = cfg_wdata[1:0];
            m_ns  = cfg_wdata[2];
            m_dis = cfg_wdata[4];
        end
        lat = m_ns ? 13 : 10;
        tv = (ctx != "") ? ctx : (m_ns ? "R3" : "R2");
        td = (ctx != "") ? ctx : fmt_tag(old_fmt);
        check(pin_valid == (m_cnt >= lat), tv, "valid", 32'(pin_valid), 32'(m_cnt >= lat));
        check(pin_oe == !m_dis, (ctx != "") ? ctx : "R8", "output enable", 32'(pin_oe), 32'(!m_dis));
        if (m_cnt >= lat) begin
            exp_d = enc(old_fmt, hist[lat-1][W-1:0]);
            exp_o = hist[lat-1][W];
            check(pin_ovr == exp_o, (ctx != "") ? ctx : "R4", "overrange", 32'(pin_ovr), 32'(exp_o));
            if (pin_oe) check(pin_data == exp_d, td, "data", 32'(pin_data), 32'(exp_d));
        end
        cfg_we    = 1'b0;
        smp_code  = W'($urandom);
        smp_ovr   = ($urandom % 8) == 0;
    endtask

    task automatic write(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'h5eed_0c0d));
        for (int i = 0; i < 16; i++) hist[i] = '0;
        repeat (4) @(negedge clk);
        // R1: defaults held during reset
        check(pin_oe == 1'b1, "R1", "oe in reset", 32'(pin_oe), 32'd1);
        check(pin_valid == 1'b0, "R1", "valid in reset", 32'(pin_valid), 32'd0);
        rst_n = 1'b1;
        ctx = "R1";
        run(12);
        ctx = "";
        run(30);
        // R6: full-scale points in two's complement, with overrange flags
        ctx = "R6";
        smp_code = 11'h000; smp_ovr = 1'b1; step();
        smp_code = 11'h400; smp_ovr = 1'b0; step();
        smp_code = 11'h7FF; smp_ovr = 1'b1; step();
        run(12);
        // R5: offset binary including full scale
        ctx = "R5";
        write(8'h14, 8'h00);
        smp_code = 11'h000; smp_ovr = 1'b1; step();
        smp_code = 11'h400; step();
        smp_code = 11'h7FF; step();
        run(15);
        ctx = "R7";
        write(8'h14, 8'h02);
        run(20);
        write(8'h14, 8'h03);
        run(12);
        // R11: format change with no flush
        ctx = "R11";
        write(8'h14, 8'h00);
        run(3);
        write(8'h14, 8'h02);
        run(3);
        // R10: switch to long latency
        ctx = "R10";
        write(8'h14, 8'h05);
        run(16);
        ctx = "";
        run(20);
        // R9: foreign address, data that would flush and disable
        ctx = "R9";
        write(8'h15, 8'h10);
        write(8'h04, 8'h00);
        run(5);
        // R8: output disable and re-enable
        ctx = "R8";
        write(8'h14, 8'h15);
        run(4);
        write(8'h14, 8'h05);
        run(4);
        // R10: back to short latency, then same-mode write (no flush)
        ctx = "R10";
        write(8'h14, 8'h01);
        run(12);
        write(8'h14, 8'h01);
        run(3);
        ctx = "";
        // Random mix of streams and configuration writes
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 20) == 0) begin
                write(($urandom % 4 == 0) ? 8'h20 : 8'h14, 8'($urandom) & 8'h17);
            end else begin
                step();
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule